// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block performs the state update a processor core needs when it takes a vectored interrupt from an external interrupt controller. Each request carries four items: a handler address, a target register set, an interrupt level and a non-maskable flag. The block reads the current status word and the address of the interrupted instruction. From these it derives the new status word and the new PC. It also decides where the previous status and the return address are saved. They go either to the exception-status control register or to slots in the chosen shadow register set.

A request is taken when `req_valid` and `req_ready` are both high at a rising clock edge. One cycle later the block drives single-cycle write strobes with their data. The strobes cover the status register, the exception-status register, one shadow set (its saved-status slot and its return-address slot) and the PC. `req_ready` is low in that write cycle. This lets the register file commit the new status before the next request reads it.

Status word layout: U (user mode) is bit 0. EH (exception handling) is bit 1. IH (interrupt handler) is bit 2. NMI is bit 3. RSIE (register-set interrupt enable) is bit 4. SRS (set changed) is bit 5. IL (interrupt level) is bits [11:6]. CRS (current set) is bits [13:12]. PRS (previous set) is bits [15:14]. Bits [31:16] are carried through unchanged.

Top module: `vec_irq_entry`

## Requirements
- R1: A request is accepted only at a rising edge where `req_valid` and `req_ready` are both high. The strobes pulse for exactly the one cycle after the acceptance, and `req_ready` is low during that cycle. A `req_valid` seen while `req_ready` is low causes no write.
- R2: `pc_wdata` equals the request's handler address, with `pc_we` high. When the return address is saved, its value is the interrupted PC plus 4.
- R3: In the new status, CRS (bits [13:12]) equals the requested set, IL (bits [11:6]) equals the requested level and NMI (bit 3) equals the request's NMI flag.
- R4: In the new status, RSIE (bit 4) and U (bit 0) are cleared and IH (bit 2) is set. EH (bit 1), SRS (bit 5) and bits [31:16] keep their old values.
- R5: When EH is clear in the old status, PRS (bits [15:14]) takes the old CRS. The return address is then written to the return-address slot of the requested set (`shadow_ea_we`, with `shadow_set` = requested set).
- R6: When EH is clear and the requested set is 0, the old status is written unchanged to the exception-status register, and no shadow status slot is written.
- R7: When EH is clear and the requested set is nonzero, the old status is written to that set's status slot and the exception-status register is not written. SRS (bit 5) is set in the saved value when the requested set differs from the old CRS. Otherwise the saved value equals the old status.
- R8: When EH is set in the old status, PRS keeps its old value. Neither the exception-status register nor any shadow slot is written. The status and PC writes still happen.
- R9: While `rst_n` is low, all write strobes and `req_ready` are low. In the first cycle after reset is released, `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request present |
| req_ready | output | 1 | Block can accept a request |
| req_handler | input | 32 | Handler address |
| req_set | input | 2 | Requested register set |
| req_level | input | 6 | Requested interrupt level |
| req_nmi | input | 1 | Non-maskable flag |
| cur_status | input | 32 | Current status word |
| cur_pc | input | 32 | Address of interrupted instruction |
| status_we | output | 1 | Status register write strobe |
| status_wdata | output | 32 | New status word |
| estatus_we | output | 1 | Exception-status register write strobe |
| estatus_wdata | output | 32 | Saved status for exception-status register |
| shadow_set | output | 2 | Shadow set addressed by the slot writes |
| shadow_st_we | output | 1 | Shadow status slot write strobe |
| shadow_st_wdata | output | 32 | Saved status for shadow slot |
| shadow_ea_we | output | 1 | Shadow return-address slot write strobe |
| shadow_ea_wdata | output | 32 | Return address |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | New PC |

## Verification
The entry sequence is driven with random old status words and random target sets, levels and flags. Directed cases are added for each branch of the save decision:
- EH set, where nothing may be saved.
- Requested set 0, where the save goes to exception-status.
- Nonzero set equal to the old CRS, where SRS stays as it was.
- Nonzero set different from the old CRS, where SRS is forced.

Old status words with every bit set and with every bit clear show that clear, set and carried bits are handled separately. A request held during the write cycle checks that the handshake blocks a second entry.

// File: rtl/vec_irq_entry.sv
module vec_irq_entry #(
  parameter int DW    = 32,
  parameter int SET_W = 2,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DW-1:0]    req_handler,
  input  logic [SET_W-1:0] req_set,
  input  logic [LVL_W-1:0] req_level,
  input  logic             req_nmi,
  input  logic [DW-1:0]    cur_status,
  input  logic [DW-1:0]    cur_pc,
  output logic             status_we,
  output logic [DW-1:0]    status_wdata,
  output logic             estatus_we,
  output logic [DW-1:0]    estatus_wdata,
  output logic [SET_W-1:0] shadow_set,
  output logic             shadow_st_we,
  output logic [DW-1:0]    shadow_st_wdata,
  output logic             shadow_ea_we,
  output logic [DW-1:0]    shadow_ea_wdata,
  output logic             pc_we,
  output logic [DW-1:0]    pc_wdata
);
  localparam int U_B    = 0;
  localparam int EH_B   = 1;
  localparam int IH_B   = 2;
  localparam int NMI_B  = 3;
  localparam int RSIE_B = 4;
  localparam int SRS_B  = 5;
  localparam int IL_LO  = 6;
  localparam int CRS_LO = IL_LO + LVL_W;
  localparam int PRS_LO = CRS_LO + SET_W;

  logic             accept, eh_clr, to_shadow;
  logic [SET_W-1:0] old_crs;
  logic [DW-1:0]    nst, saved;

  assign accept    = req_valid & req_ready;
  assign old_crs   = cur_status[CRS_LO +: SET_W];
  assign eh_clr    = ~cur_status[EH_B];
  assign to_shadow = req_set != '0;

  always_comb begin
    nst = cur_status;
    nst[CRS_LO +: SET_W] = req_set;
    nst[IL_LO +: LVL_W]  = req_level;
    nst[NMI_B]  = req_nmi;
    nst[RSIE_B] = 1'b0;
    nst[U_B]    = 1'b0;
    nst[IH_B]   = 1'b1;
    if (eh_clr) nst[PRS_LO +: SET_W] = old_crs;
  end

  always_comb begin
    saved = cur_status;
    if (req_set != old_crs) saved[SRS_B] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ready       <= 1'b0;
      status_we       <= 1'b0;
      estatus_we      <= 1'b0;
      shadow_st_we    <= 1'b0;
      shadow_ea_we    <= 1'b0;
      pc_we           <= 1'b0;
      status_wdata    <= '0;
      estatus_wdata   <= '0;
      shadow_set      <= '0;
      shadow_st_wdata <= '0;
      shadow_ea_wdata <= '0;
      pc_wdata        <= '0;
    end else begin
      req_ready    <= ~accept;
      status_we    <= accept;
      pc_we        <= accept;
      estatus_we   <= accept & eh_clr & ~to_shadow;
      shadow_st_we <= accept & eh_clr & to_shadow;
      shadow_ea_we <= accept & eh_clr;
      if (accept) begin
        status_wdata    <= nst;
        estatus_wdata   <= cur_status;
        shadow_set      <= req_set;
        shadow_st_wdata <= saved;
        shadow_ea_wdata <= cur_pc + DW'(4);
        pc_wdata        <= req_handler;
      end
    end
  end
endmodule

module vec_irq_entry_chk #(
  parameter int DW    = 32,
  parameter int SET_W = 2,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [DW-1:0]    req_handler,
  input logic [SET_W-1:0] req_set,
  input logic [DW-1:0]    cur_status,
  input logic             status_we,
  input logic [DW-1:0]    status_wdata,
  input logic             estatus_we,
  input logic [SET_W-1:0] shadow_set,
  input logic             shadow_st_we,
  input logic             shadow_ea_we,
  input logic             pc_we,
  input logic [DW-1:0]    pc_wdata
);
  localparam int CRS_LO = 6 + LVL_W;
  localparam int PRS_LO = CRS_LO + SET_W;

  // R1
  write_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |-> $past(req_valid && req_ready));
  // R1
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |-> !req_ready);
  // R2
  handler_to_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> pc_wdata == $past(req_handler));
  // R5
  prs_from_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_ea_we |-> status_wdata[PRS_LO +: SET_W] == $past(cur_status[CRS_LO +: SET_W]));
  // R6
  single_status_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(estatus_we && shadow_st_we));
  // R7
  shadow_save_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_st_we |-> shadow_set != '0 && shadow_set == $past(req_set));
  // R8
  eh_blocks_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_we && $past(cur_status[1])) |-> !estatus_we && !shadow_st_we && !shadow_ea_we);
endmodule

bind vec_irq_entry vec_irq_entry_chk #(.DW(DW), .SET_W(SET_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_handler(req_handler), .req_set(req_set), .cur_status(cur_status),
  .status_we(status_we), .status_wdata(status_wdata), .estatus_we(estatus_we),
  .shadow_set(shadow_set), .shadow_st_we(shadow_st_we), .shadow_ea_we(shadow_ea_we),
  .pc_we(pc_we), .pc_wdata(pc_wdata));

// File: tb/vec_irq_entry_bench.sv
module vec_irq_entry_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_nmi = 1'b0;
  logic [31:0] req_handler = '0, cur_status = '0, cur_pc = '0;
  logic [1:0]  req_set = '0;
  logic [5:0]  req_level = '0;
  logic        req_ready, status_we, estatus_we, shadow_st_we, shadow_ea_we, pc_we;
  logic [31:0] status_wdata, estatus_wdata, shadow_st_wdata, shadow_ea_wdata, pc_wdata;
  logic [1:0]  shadow_set;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  vec_irq_entry u_vec_irq_entry (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_handler(req_handler), .req_set(req_set), .req_level(req_level),
    .req_nmi(req_nmi), .cur_status(cur_status), .cur_pc(cur_pc),
    .status_we(status_we), .status_wdata(status_wdata),
    .estatus_we(estatus_we), .estatus_wdata(estatus_wdata),
    .shadow_set(shadow_set), .shadow_st_we(shadow_st_we),
    .shadow_st_wdata(shadow_st_wdata), .shadow_ea_we(shadow_ea_we),
    .shadow_ea_wdata(shadow_ea_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(logic [31:0] s, logic [1:0] set,
                                             logic [5:0] lvl, logic nmi);
    logic [31:0] r = s;
    r[13:12] = set; r[11:6] = lvl; r[3] = nmi;
    r[4] = 1'b0; r[0] = 1'b0; r[2] = 1'b1;
    if (!s[1]) r[15:14] = s[13:12];
    return r;
  endfunction

  function automatic logic [31:0] exp_saved(logic [31:0] s, logic [1:0] set);
    logic [31:0] r = s;
    if (set != s[13:12]) r[5] = 1'b1;
    return r;
  endfunction

  task automatic entry(input logic [31:0] h, input logic [1:0] set, input logic [5:0] lvl,
                       input logic nmi, input logic [31:0] st, input logic [31:0] pc,
                       input bit hold);
    logic eh_clr = !st[1];
    @(negedge clk);
    req_handler = h; req_set = set; req_level = lvl; req_nmi = nmi;
    cur_status = st; cur_pc = pc; req_valid = 1'b1;
    chk("R1 ready before accept", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    chk("R1 ready low in write cycle", {31'b0, req_ready}, 32'd0);
    chk("R1 status_we", {31'b0, status_we}, 32'd1);
    chk("R2 pc_we", {31'b0, pc_we}, 32'd1);
    chk("R2 pc_wdata", pc_wdata, h);
    chk("R3 R4 R5 status_wdata", status_wdata, exp_status(st, set, lvl, nmi));
    chk("R5 R8 shadow_ea_we", {31'b0, shadow_ea_we}, {31'b0, eh_clr});
    if (eh_clr) begin
      chk("R2 return address", shadow_ea_wdata, pc + 32'd4);
      chk("R5 shadow_set", {30'b0, shadow_set}, {30'b0, set});
    end
    chk("R6 R8 estatus_we", {31'b0, estatus_we}, {31'b0, eh_clr && set == 2'd0});
    chk("R7 R8 shadow_st_we", {31'b0, shadow_st_we}, {31'b0, eh_clr && set != 2'd0});
    if (eh_clr && set == 2'd0) chk("R6 estatus_wdata", estatus_wdata, st);
    if (eh_clr && set != 2'd0) chk("R7 shadow_st_wdata", shadow_st_wdata, exp_saved(st, set));
    @(negedge clk);
    if (hold) begin
      chk("R1 held request ignored", {26'b0, status_we, pc_we, estatus_we,
          shadow_st_we, shadow_ea_we, req_ready}, 32'd1);
      req_valid = 1'b0;
    end else begin
      chk("R1 no strobe without accept", {31'b0, status_we | pc_we}, 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R9 ready low in reset", {31'b0, req_ready}, 32'd0);
    chk("R9 strobes low in reset", {27'b0, status_we, estatus_we, shadow_st_we,
        shadow_ea_we, pc_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", {31'b0, req_ready}, 32'd1);
    // directed: R6 set 0, R7 same set, R7 changed set, R8 EH set, all-ones/all-zeros
    entry(32'h0000_1000, 2'd0, 6'd5,  1'b0, 32'h0000_0000, 32'h0000_0100, 1'b0);
    entry(32'h0000_2000, 2'd2, 6'd9,  1'b1, 32'h0000_2011, 32'h0000_0200, 1'b0);
    entry(32'h0000_3000, 2'd3, 6'd63, 1'b0, 32'h0000_1011, 32'h0000_0300, 1'b0);
    entry(32'h0000_4000, 2'd1, 6'd1,  1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 1'b0);
    entry(32'h0000_5000, 2'd1, 6'd2,  1'b0, 32'hFFFF_FFFD, 32'h0000_0400, 1'b1);
    entry(32'h0000_6000, 2'd0, 6'd0,  1'b1, 32'h0000_0002, 32'h0000_0500, 1'b0);
    for (int i = 0; i < 400; i++)
      entry($urandom, 2'($urandom), 6'($urandom), 1'($urandom),
            $urandom, $urandom, ($urandom % 8) == 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule